// File: doc/BRIEF.md
# Interval Timer Host Port and Control Decoder

This block is the processor-facing side of a three-channel interval timer. A two-bit address picks one of three channel data ports or a shared control port. An active-low chip select, separate read and write strobes and an 8-bit bidirectional data bus carry each transfer. A control word names its target channel in its top two bits. The block keeps that channel's counting mode, BCD flag and byte format.

Count values arrive one byte at a time. The block joins them into 16-bit values and hands each finished value to the counting logic with a one-cycle load strobe. On reads it returns bytes of the live count that the counting logic supplies, or of a snapshot taken by a latch command. The counters and any status readback are outside this block.

All transfers are synchronous. A write or read is one access for each rising clock edge at which it is asserted.

Top module: `ivt_host_port`

## Requirements
- R1: An access happens at a rising edge with `cs_n`=0 and exactly one of `rd_n`/`wr_n` low. Address 0, 1 and 2 select the channel data ports and address 3 the control port. With `cs_n`=1, or with both strobes low, nothing is stored and nothing advances.
- R2: A control write takes its fields from the data bus: bit 0 is BCD, bits 3:1 are the mode, bits 5:4 are the format and bits 7:6 are the channel. The formats are 01 low byte only, 10 high byte only and 11 low then high. The target channel's `ch_mode`, `ch_bcd` and `ch_fmt` show the new values from the next edge on. Other channels are unchanged.
- R3: A control write with channel field 11 changes no output and no channel state.
- R4: A control word with format 00 is a latch command. It captures that channel's live count and leaves its mode, BCD flag and format unchanged.
- R5: Until a channel has received a control word with a nonzero format, writes to its data port are ignored (no load strobe) and reads of it return 8'h00.
- R6: In format 01 a data write loads {8'h00, byte}. In format 10 it loads {byte, 8'h00}. The strobe and the value appear on `ch_load`/`ch_count` in the cycle after the write edge.
- R7: In format 11 the first data write stores the low byte without a strobe. The second loads {second, first} with a strobe. The write byte pointer then returns to low.
- R8: A control word with a nonzero format returns both byte pointers of its channel to the low byte.
- R9: A read returns the low byte in format 01 and the high byte in format 10. In format 11 reads alternate low, high. The bytes come from the live count unless a latch is held.
- R10: A latched value is held until it has been read out: one read in formats 01/10, low and high in format 11. Reads then return the live count. A latch command that arrives while a latch is held is ignored.
- R11: The block drives `data` only while `cs_n`=0 and `rd_n`=0. A read of the control port returns 8'h00.
- R12: `ch_load` for a channel is a single-cycle pulse for each completed count write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Port select: 0..2 channel, 3 control |
| data | inout | 8 | Bidirectional data bus |
| ch_live | input | 48 | Live count of each channel, channel k in bits 16k+15:16k |
| ch_mode | output | 9 | Stored mode, 3 bits per channel |
| ch_bcd | output | 3 | Stored BCD flag per channel |
| ch_fmt | output | 6 | Stored byte format, 2 bits per channel |
| ch_load | output | 3 | Load strobe per channel |
| ch_count | output | 48 | Count value loaded with the strobe, 16 bits per channel |

## Verification
All stored results are registered once. Mode, format, BCD, load strobe and count change one edge after the write that caused them. The bench drives every access at a falling edge and holds it for one full cycle. It checks the registered outputs at the next falling edge, which is the first point after the capturing edge. A second falling-edge sample confirms that the strobe has dropped. Read data is combinational from stored state, so the bench samples the bus a nanosecond after asserting the read, inside the same cycle. The pointer and latch effects of that read are checked on the following access.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int N_CH   = 3;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_LO    = 2'b01,
        FMT_HI    = 2'b10,
        FMT_LOHI  = 2'b11
    } fmt_e;
endpackage

// File: rtl/ivt_bus_decode.sv
module ivt_bus_decode #(
    parameter int ADDR_W = 2,
    parameter int N_CH   = 3
) (
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_ctl,
    output logic [N_CH-1:0]   wr_ch,
    output logic [N_CH-1:0]   rd_ch,
    output logic              drive_en
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(N_CH);

    logic sel, do_wr, do_rd;

    always_comb begin
        sel      = !cs_n;
        do_wr    = sel && !wr_n && rd_n;
        do_rd    = sel && !rd_n && wr_n;
        drive_en = sel && !rd_n;
        wr_ctl   = do_wr && (addr == CTL_ADDR);
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_port
        assign wr_ch[k] = do_wr && (addr == ADDR_W'(k));
        assign rd_ch[k] = do_rd && (addr == ADDR_W'(k));
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MODE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_we,
    input  logic                  latch_req,
    input  logic [DATA_W-1:0]     ctl_word,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [DATA_W-1:0]     wdat,
    input  logic [2*DATA_W-1:0]   live,
    output logic [MODE_W-1:0]     mode,
    output logic                  bcd,
    output logic [1:0]            fmt,
    output logic                  load,
    output logic [2*DATA_W-1:0]   load_val,
    output logic [DATA_W-1:0]     rd_byte
);
    localparam int CW       = 2 * DATA_W;
    localparam int BCD_BIT  = 0;
    localparam int MODE_LSB = 1;
    localparam int FMT_LSB  = MODE_LSB + MODE_W;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              bcd;
        logic [1:0]        fmt;
        logic              armed;
        logic              wptr;
        logic              rptr;
        logic [DATA_W-1:0] lo_hold;
        logic              latched;
        logic [CW-1:0]     snap;
        logic              load;
        logic [CW-1:0]     load_val;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;

        if (ctl_we) begin
            st_d.mode    = ctl_word[MODE_LSB +: MODE_W];
            st_d.bcd     = ctl_word[BCD_BIT];
            st_d.fmt     = ctl_word[FMT_LSB +: 2];
            st_d.armed   = 1'b1;
            st_d.wptr    = 1'b0;
            st_d.rptr    = 1'b0;
            st_d.latched = 1'b0;
        end else if (latch_req) begin
            if (st_q.armed && !st_q.latched) begin
                st_d.latched = 1'b1;
                st_d.snap    = live;
            end
        end

        if (wr_en && st_q.armed) begin
            unique case (fmt_e'(st_q.fmt))
                FMT_LO: begin
                    st_d.load     = 1'b1;
                    st_d.load_val = {{DATA_W{1'b0}}, wdat};
                end
                FMT_HI: begin
                    st_d.load     = 1'b1;
                    st_d.load_val = {wdat, {DATA_W{1'b0}}};
                end
                FMT_LOHI: begin
                    if (!st_q.wptr) begin
                        st_d.lo_hold = wdat;
                        st_d.wptr    = 1'b1;
                    end else begin
                        st_d.load     = 1'b1;
                        st_d.load_val = {wdat, st_q.lo_hold};
                        st_d.wptr     = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (rd_en && st_q.armed) begin
            if (fmt_e'(st_q.fmt) == FMT_LOHI) begin
                st_d.rptr = !st_q.rptr;
                if (st_q.rptr) st_d.latched = 1'b0;
            end else begin
                st_d.latched = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.fmt      <= FMT_LO;
        end else begin
            st_q <= st_d;
        end
    end

    logic [CW-1:0] src;
    logic          take_hi;

    always_comb begin
        src = st_q.latched ? st_q.snap : live;
        unique case (fmt_e'(st_q.fmt))
            FMT_HI:   take_hi = 1'b1;
            FMT_LOHI: take_hi = st_q.rptr;
            default:  take_hi = 1'b0;
        endcase
        if (!st_q.armed)  rd_byte = '0;
        else if (take_hi) rd_byte = src[CW-1:DATA_W];
        else              rd_byte = src[DATA_W-1:0];
    end

    assign mode     = st_q.mode;
    assign bcd      = st_q.bcd;
    assign fmt      = st_q.fmt;
    assign load     = st_q.load;
    assign load_val = st_q.load_val;
endmodule

// File: rtl/ivt_rd_mux.sv
module ivt_rd_mux #(
    parameter int DATA_W = 8,
    parameter int N_CH   = 3
) (
    input  logic [N_CH-1:0]        sel,
    input  logic [N_CH*DATA_W-1:0] bytes_in,
    output logic [DATA_W-1:0]      dout
);
    always_comb begin
        dout = '0;
        for (int k = 0; k < N_CH; k++) begin
            if (sel[k]) dout = dout | bytes_in[k*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/ivt_host_port.sv
module ivt_host_port
    import ivt_pkg::*;
#(
    parameter int DW    = ivt_pkg::DATA_W,
    parameter int MW    = ivt_pkg::MODE_W,
    parameter int AW    = ivt_pkg::ADDR_W,
    parameter int NC    = ivt_pkg::N_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [AW-1:0]     addr,
    inout  wire  [DW-1:0]     data,
    input  logic [NC*2*DW-1:0] ch_live,
    output logic [NC*MW-1:0]  ch_mode,
    output logic [NC-1:0]     ch_bcd,
    output logic [NC*2-1:0]   ch_fmt,
    output logic [NC-1:0]     ch_load,
    output logic [NC*2*DW-1:0] ch_count
);
    localparam int CW      = 2 * DW;
    localparam int CH_MSB  = DW - 1;
    localparam int CH_LSB  = DW - 2;
    localparam int FMT_LSB = 1 + MW;

    logic [DW-1:0]    data_in;
    logic [DW-1:0]    rdat;
    logic             wr_ctl;
    logic [NC-1:0]    wr_ch, rd_ch;
    logic             drive_en;
    logic [NC*DW-1:0] rd_bytes;
    logic [1:0]       tgt;
    logic [1:0]       ctl_fmt;

    assign data_in = data;
    assign data    = drive_en ? rdat : {DW{1'bz}};
    assign tgt     = data_in[CH_MSB:CH_LSB];
    assign ctl_fmt = data_in[FMT_LSB +: 2];

    ivt_bus_decode #(.ADDR_W(AW), .N_CH(NC)) u_dec (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .wr_ctl   (wr_ctl),
        .wr_ch    (wr_ch),
        .rd_ch    (rd_ch),
        .drive_en (drive_en)
    );

    for (genvar k = 0; k < NC; k++) begin : g_ch
        logic hit, ctl_we, latch_req;
        assign hit       = wr_ctl && (tgt == 2'(k));
        assign ctl_we    = hit && (ctl_fmt != FMT_LATCH);
        assign latch_req = hit && (ctl_fmt == FMT_LATCH);

        ivt_channel #(.DATA_W(DW), .MODE_W(MW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we),
            .latch_req (latch_req),
            .ctl_word  (data_in),
            .wr_en     (wr_ch[k]),
            .rd_en     (rd_ch[k]),
            .wdat      (data_in),
            .live      (ch_live[k*CW +: CW]),
            .mode      (ch_mode[k*MW +: MW]),
            .bcd       (ch_bcd[k]),
            .fmt       (ch_fmt[k*2 +: 2]),
            .load      (ch_load[k]),
            .load_val  (ch_count[k*CW +: CW]),
            .rd_byte   (rd_bytes[k*DW +: DW])
        );
    end

    ivt_rd_mux #(.DATA_W(DW), .N_CH(NC)) u_mux (
        .sel      (rd_ch),
        .bytes_in (rd_bytes),
        .dout     (rdat)
    );
endmodule

// File: rtl/ivt_host_port_chk.sv
module ivt_host_port_chk #(
    parameter int DW = 8,
    parameter int MW = 3,
    parameter int AW = 2,
    parameter int NC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     wdat,
    input logic [NC*MW-1:0]  ch_mode,
    input logic [NC-1:0]     ch_bcd,
    input logic [NC*2-1:0]   ch_fmt,
    input logic [NC-1:0]     ch_load,
    input logic [NC*2*DW-1:0] ch_count
);
    localparam int CW = 2 * DW;

    logic ctl_wr;
    assign ctl_wr = !cs_n && !wr_n && rd_n && (addr == AW'(NC));

    // R3
    bad_channel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdat[DW-1:DW-2] == 2'b11) |=>
            ($stable(ch_mode) && $stable(ch_fmt) && $stable(ch_bcd)));

    // R4
    latch_keeps_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdat[DW-3:DW-4] == 2'b00) |=>
            ($stable(ch_mode) && $stable(ch_fmt) && $stable(ch_bcd)));

    for (genvar k = 0; k < NC; k++) begin : g_k
        // R12
        load_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_load[k]) |-> $past(!cs_n && !wr_n && rd_n && addr == AW'(k)));

        // R2
        fmt_never_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_fmt[k*2 +: 2] != 2'b00);

        // R6
        lo_only_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_load[k] && ch_fmt[k*2 +: 2] == 2'b01) |->
                (ch_count[k*CW+DW +: DW] == '0));

        // R6
        hi_only_lower_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_load[k] && ch_fmt[k*2 +: 2] == 2'b10) |->
                (ch_count[k*CW +: DW] == '0));
    end
endmodule

bind ivt_host_port ivt_host_port_chk #(.DW(DW), .MW(MW), .AW(AW), .NC(NC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .wdat     (data_in),
    .ch_mode  (ch_mode),
    .ch_bcd   (ch_bcd),
    .ch_fmt   (ch_fmt),
    .ch_load  (ch_load),
    .ch_count (ch_count)
);

// File: tb/ivt_host_port_tb_top.sv
module ivt_host_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  tb_d = 8'h00;
    logic        tb_oe = 1'b0;
    wire  [7:0]  bus;
    logic [47:0] live = '0;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [5:0]  ch_fmt;
    logic [2:0]  ch_load;
    logic [47:0] ch_count;
    int          n_vec = 0;
    int          n_bad = 0;
    logic        done = 1'b0;

    assign bus = tb_oe ? tb_d : 8'bz;

    always #2 clk = !clk;

    ivt_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .data(bus), .ch_live(live), .ch_mode(ch_mode),
        .ch_bcd(ch_bcd), .ch_fmt(ch_fmt), .ch_load(ch_load), .ch_count(ch_count)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; tb_d = d; tb_oe = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; tb_oe = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = bus;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset;
        chk("R2 reset mode", 48'(ch_mode), 48'h0);
        chk("R2 reset fmt", 48'(ch_fmt), 48'(6'b010101));
        chk("R12 reset load", 48'(ch_load), 48'h0);
        chk("R2 reset bcd", 48'(ch_bcd), 48'h0);
    endtask

    task automatic t_unarmed;
        logic [7:0] v;
        live[15:0] = 16'h1234;
        wr(2'd0, 8'h55);
        chk("R5 no load before control", 48'(ch_load), 48'h0);
        rd(2'd0, v);
        chk("R5 unarmed read", 48'(v), 48'h00);
    endtask

    task automatic t_ctrl;
        wr(2'd3, 8'h7B);
        chk("R2 ch1 mode", 48'(ch_mode[5:3]), 48'd5);
        chk("R2 ch1 bcd", 48'(ch_bcd[1]), 48'd1);
        chk("R2 ch1 fmt", 48'(ch_fmt[3:2]), 48'd3);
        chk("R2 others untouched", 48'({ch_fmt[5:4], ch_fmt[1:0]}), 48'(4'b0101));
    endtask

    task automatic t_bad_ch;
        wr(2'd3, 8'hFF);
        chk("R3 modes unchanged", 48'(ch_mode), 48'(9'b000_101_000));
        chk("R3 fmt unchanged", 48'(ch_fmt), 48'(6'b011101));
    endtask

    task automatic t_single;
        wr(2'd3, 8'h14);
        wr(2'd0, 8'h3C);
        chk("R6 lo load strobe", 48'(ch_load), 48'(3'b001));
        chk("R6 lo value", 48'(ch_count[15:0]), 48'h003C);
        @(negedge clk);
        chk("R12 strobe one cycle", 48'(ch_load), 48'h0);
        wr(2'd3, 8'hA6);
        wr(2'd2, 8'h9A);
        chk("R6 hi load strobe", 48'(ch_load), 48'(3'b100));
        chk("R6 hi value", 48'(ch_count[47:32]), 48'h9A00);
    endtask

    task automatic t_two_byte;
        wr(2'd1, 8'h34);
        chk("R7 no strobe after low", 48'(ch_load), 48'h0);
        wr(2'd1, 8'h12);
        chk("R7 strobe after high", 48'(ch_load), 48'(3'b010));
        chk("R7 joined value", 48'(ch_count[31:16]), 48'h1234);
    endtask

    task automatic t_ptr_reset;
        wr(2'd1, 8'h78);
        wr(2'd3, 8'h7B);
        wr(2'd1, 8'hCD);
        chk("R8 pointer back to low", 48'(ch_load), 48'h0);
        wr(2'd1, 8'hAB);
        chk("R8 strobe", 48'(ch_load), 48'(3'b010));
        chk("R8 value", 48'(ch_count[31:16]), 48'hABCD);
    endtask

    task automatic t_reads;
        logic [7:0] v;
        live = {16'h2468, 16'hBEEF, 16'h1357};
        rd(2'd1, v); chk("R9 two-byte low", 48'(v), 48'hEF);
        rd(2'd1, v); chk("R9 two-byte high", 48'(v), 48'hBE);
        rd(2'd1, v); chk("R9 wraps to low", 48'(v), 48'hEF);
        rd(2'd1, v);
        rd(2'd0, v); chk("R9 low only", 48'(v), 48'h57);
        rd(2'd2, v); chk("R9 high only", 48'(v), 48'h24);
        rd(2'd3, v); chk("R11 control read", 48'(v), 48'h00);
    endtask

    task automatic t_latch;
        logic [7:0] v;
        live[31:16] = 16'h1111;
        wr(2'd3, 8'h40);
        chk("R4 mode kept", 48'(ch_mode[5:3]), 48'd5);
        chk("R4 fmt kept", 48'(ch_fmt[3:2]), 48'd3);
        live[31:16] = 16'h2222;
        rd(2'd1, v); chk("R10 latched low", 48'(v), 48'h11);
        wr(2'd3, 8'h40);
        live[31:16] = 16'h3333;
        rd(2'd1, v); chk("R10 second latch ignored", 48'(v), 48'h11);
        rd(2'd1, v); chk("R10 released to live", 48'(v), 48'h33);
        rd(2'd1, v);
        live[15:0] = 16'h00A1;
        wr(2'd3, 8'h00);
        live[15:0] = 16'h00B2;
        rd(2'd0, v); chk("R10 single-format latch", 48'(v), 48'hA1);
        rd(2'd0, v); chk("R10 single-format release", 48'(v), 48'hB2);
    endtask

    task automatic t_float;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; tb_d = 8'hA5; tb_oe = 1'b1;
        #1 chk("R11 no drive without read", 48'(bus), 48'hA5);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; tb_d = 8'h5A;
        #1 chk("R11 no drive without select", 48'(bus), 48'h5A);
        @(negedge clk);
        rd_n = 1'b1; tb_oe = 1'b0;
    endtask

    task automatic t_decode;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; tb_d = 8'h11; tb_oe = 1'b1;
        @(negedge clk);
        chk("R1 deselected write", 48'(ch_load), 48'h0);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R1 both strobes low", 48'(ch_load), 48'h0);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; tb_oe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_unarmed;
        t_ctrl;
        t_bad_ch;
        t_single;
        t_two_byte;
        t_ptr_reset;
        t_reads;
        t_latch;
        t_float;
        t_decode;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule